// File: doc/BRIEF.md
# UART Receive/Transmit Data Port Bank

This block is the bus-facing data path of a 16550-compatible serial port. It sits between a simple 32-bit register bus and the serial shift engines. Received characters from the receive shifter are stored until software reads them. Characters written by software are held until the transmit shifter takes them. Each direction works in one of two modes. With the FIFO enable input low, each direction keeps one character. With it high, each direction is a queue of `DEPTH` characters.

Sixteen consecutive word addresses, starting at byte offset 0x30, all act as one data port. A bus master can therefore burst across the range and still reach the same receive and transmit data. The block also produces the data-ready, transmitter-empty and overrun status bits, and returns them through a line-status read address. A receive-side overflow behaves differently in the two modes. With a single character, the newer character replaces the older one. With a queue, the stored characters are kept and the new character is lost. In both cases the overrun flag is raised.

Top module: `uart_dport`

## Requirements
- R1: A bus read at any word address 0x30, 0x34, … 0x6C returns the oldest stored receive character in bits [7:0], with bits [31:8] zero, and removes it. A bus write to any of those addresses offers bits [7:0] of the write data (any value 0x00 to 0xFF) to the transmit path.
- R2: Reads at addresses outside the window and other than 0x14 return zero and have no effect. Writes outside the window have no effect.
- R3: `dr` is 1 exactly while at least one receive character is stored. A window read while `dr` is 0 returns zero and changes nothing.
- R4: With `fifo_en` low, a character that arrives while one is already held, and is not read in the same cycle, replaces the held character and sets the overrun flag.
- R5: With `fifo_en` high, window reads return the received characters in arrival order.
- R6: With `fifo_en` high and `DEPTH` characters stored, an arriving character that is not matched by a read in the same cycle is discarded, the stored characters are unchanged, and the overrun flag sets.
- R7: With `fifo_en` low, a window write while `thre` is 1 clears `thre`. Further writes before the shifter takes the character replace the held character.
- R8: With `fifo_en` high, the transmit path holds up to `DEPTH` characters in write order. Writes while it is full are discarded.
- R9: `tx_avail` is 1 and `tx_char` shows the oldest transmit character while any is held. A `tx_pop` removes that character. `thre` returns to 1 once the last one is removed.
- R10: A read at 0x14 returns data-ready in bit 0, overrun in bit 1, transmitter-empty in bit 5 and zero elsewhere. The overrun flag stays set until such a read, which clears it unless a new overflow happens in the same cycle.
- R11: In the cycle where `fifo_en` differs from its value in the previous cycle, both paths are emptied and that cycle's transfers are ignored.
- R12: After reset, `dr` is 0, `thre` is 1, the overrun flag is 0 and `tx_avail` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Selects queue mode (1) or single-character mode (0) |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Receive shifter delivers a character |
| rx_char | input | 8 | Character from the receive shifter |
| tx_pop | input | 1 | Transmit shifter takes the presented character |
| tx_avail | output | 1 | A transmit character is waiting |
| tx_char | output | 8 | Oldest waiting transmit character |
| dr | output | 1 | Receive data ready |
| thre | output | 1 | Transmit path empty |
| overrun | output | 1 | Sticky receive overrun flag |

## Verification
The properties assume that `fifo_en` changes only between bus accesses, and that `tx_pop` is only raised while `tx_avail` is 1. The bench keeps to both rules: it toggles the mode only in cycles with no access, and it pops only after the model reports a waiting character. Bus accesses are whole-word aligned, and at most one access happens per cycle. Receive arrivals and bus reads are sometimes placed in the same cycle, so the pop-before-push ordering on a full path is exercised under that same set of assumptions.

// File: rtl/uart_dport_pkg.sv
package uart_dport_pkg;
    localparam int CHAR_W       = 8;
    localparam int BUS_W        = 32;
    localparam int STS_DR_BIT   = 0;
    localparam int STS_OE_BIT   = 1;
    localparam int STS_THRE_BIT = 5;

    typedef struct packed {
        logic mode_en;
        logic ovr;
    } top_state_t;
endpackage

// File: rtl/uart_dport_dec.sv
module uart_dport_dec #(
    parameter int ADDR_W   = 8,
    parameter int WIN_BASE = 'h30,
    parameter int WIN_CNT  = 16,
    parameter int STS_OFF  = 'h14
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              win_rd,
    output logic              win_wr,
    output logic              sts_rd
);
    localparam int WIN_END = WIN_BASE + 4 * WIN_CNT;

    logic in_win;

    always_comb begin
        in_win = (int'(addr) >= WIN_BASE) && (int'(addr) < WIN_END);
        win_rd = sel && !wr && in_win;
        win_wr = sel && wr && in_win;
        sts_rd = sel && !wr && (int'(addr) == STS_OFF);
    end
endmodule

// File: rtl/uart_dport_fifo.sv
module uart_dport_fifo #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       single,
    input  logic       push,
    input  logic       pop,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       empty,
    output logic       drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      rd;
        logic [PTR_W-1:0]      wr;
        logic [CNT_W-1:0]      cnt;
    } fifo_t;

    fifo_t st_d, st_q;

    logic             do_pop;
    logic             full;
    logic             take;
    logic [CNT_W-1:0] cap;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        cap    = single ? CNT_W'(1) : CNT_W'(DEPTH);
        do_pop = pop && (st_q.cnt != '0) && !flush;
        full   = st_q.cnt >= cap;
        take   = push && !flush && (!full || do_pop);
        drop   = push && !flush && full && !do_pop;
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_pop) begin
                st_d.rd = nxt(st_q.rd);
            end
            if (take) begin
                st_d.mem[st_q.wr] = din;
                st_d.wr           = nxt(st_q.wr);
            end else if (drop && single) begin
                st_d.mem[st_q.rd] = din;
            end
            st_d.cnt = st_q.cnt + CNT_W'(take) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign empty = (st_q.cnt == '0);
    assign dout  = empty ? 8'h00 : st_q.mem[st_q.rd];
endmodule

// File: rtl/uart_dport.sv
module uart_dport
    import uart_dport_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int ADDR_W   = 8,
    parameter int WIN_BASE = 'h30,
    parameter int WIN_CNT  = 16,
    parameter int STS_OFF  = 'h14,
    parameter bit ALIAS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_char,
    input  logic              tx_pop,
    output logic              tx_avail,
    output logic [7:0]        tx_char,
    output logic              dr,
    output logic              thre,
    output logic              overrun
);
    top_state_t st_d, st_q;

    logic       win_rd_raw, win_wr_raw, sts_rd;
    logic       win_rd, win_wr;
    logic       flush;
    logic       rx_empty, tx_empty, rx_drop, tx_drop;
    logic [7:0] rx_head;
    logic       en_q;

    uart_dport_dec #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE),
        .WIN_CNT (WIN_CNT),
        .STS_OFF (STS_OFF)
    ) u_dec (
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .win_rd(win_rd_raw),
        .win_wr(win_wr_raw),
        .sts_rd(sts_rd)
    );

    assign win_rd = win_rd_raw && ALIAS_EN;
    assign win_wr = win_wr_raw && ALIAS_EN;
    assign flush  = (fifo_en != st_q.mode_en);
    assign en_q   = st_q.mode_en;

    uart_dport_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .single(!fifo_en),
        .push  (rx_valid),
        .pop   (win_rd),
        .din   (rx_char),
        .dout  (rx_head),
        .empty (rx_empty),
        .drop  (rx_drop)
    );

    uart_dport_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .single(!fifo_en),
        .push  (win_wr),
        .pop   (tx_pop),
        .din   (bus_wdata[7:0]),
        .dout  (tx_char),
        .empty (tx_empty),
        .drop  (tx_drop)
    );

    always_comb begin
        st_d         = st_q;
        st_d.mode_en = fifo_en;
        st_d.ovr     = rx_drop || (st_q.ovr && !sts_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dr       = !rx_empty;
    assign thre     = tx_empty;
    assign tx_avail = !tx_empty;
    assign overrun  = st_q.ovr;

    always_comb begin
        bus_rdata = '0;
        if (win_rd_raw) begin
            if (ALIAS_EN) begin
                bus_rdata[7:0] = rx_head;
            end
        end else if (sts_rd) begin
            bus_rdata[STS_DR_BIT]   = !rx_empty;
            bus_rdata[STS_OE_BIT]   = st_q.ovr;
            bus_rdata[STS_THRE_BIT] = tx_empty;
        end
    end
endmodule

// File: rtl/uart_dport_chk.sv
module uart_dport_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fifo_en,
    input logic        en_q,
    input logic        win_rd,
    input logic        win_wr,
    input logic        sts_rd,
    input logic        rx_drop,
    input logic        dr,
    input logic        thre,
    input logic        overrun,
    input logic [31:0] bus_rdata
);
    AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |=> overrun); // R6

    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !rx_drop) |=> !overrun); // R10

    AST_THRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (thre && win_wr && (fifo_en == en_q)) |=> !thre); // R7

    AST_DR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dr && !win_rd && (fifo_en == en_q)) |=> dr); // R3

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && !dr) |-> (bus_rdata == 32'h0)); // R3
endmodule

bind uart_dport uart_dport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .en_q     (en_q),
    .win_rd   (win_rd_raw),
    .win_wr   (win_wr),
    .sts_rd   (sts_rd),
    .rx_drop  (rx_drop),
    .dr       (dr),
    .thre     (thre),
    .overrun  (overrun),
    .bus_rdata(bus_rdata)
);

// File: tb/uart_dport_bench.sv
module uart_dport_bench;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        tx_pop = 1'b0;
    logic        tx_avail;
    logic [7:0]  tx_char;
    logic        dr, thre, overrun;

    always #10 clk = ~clk;

    uart_dport #(.DEPTH(DEPTH)) u_uart_dport (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_char(rx_char), .tx_pop(tx_pop),
        .tx_avail(tx_avail), .tx_char(tx_char),
        .dr(dr), .thre(thre), .overrun(overrun)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string req = "R12";

    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    bit m_ovr = 0;
    bit m_en = 0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [7:0] a);
        return (a >= 8'h30) && (a < 8'h70);
    endfunction

    task automatic tick();
        logic [31:0] exp_rd;
        bit flush, rpop, tpop, full;
        int cap;
        #1;
        exp_rd = 0;
        if (bus_sel && !bus_wr) begin
            if (in_win(bus_addr)) exp_rd = (rxq.size() > 0) ? {24'h0, rxq[0]} : 0;
            else if (bus_addr == 8'h14)
                exp_rd = {26'h0, txq.size() == 0, 3'b000, m_ovr, rxq.size() > 0};
        end
        chk("dr", dr, rxq.size() > 0);
        chk("thre", thre, txq.size() == 0);
        chk("overrun", overrun, m_ovr);
        chk("tx_avail", tx_avail, txq.size() > 0);
        chk("tx_char", tx_char, (txq.size() > 0) ? txq[0] : 8'h00);
        chk("rdata", bus_rdata, exp_rd);
        @(posedge clk);
        flush = (fifo_en != m_en);
        cap = fifo_en ? DEPTH : 1;
        if (flush) begin
            rxq.delete();
            txq.delete();
            m_ovr = m_ovr && !(bus_sel && !bus_wr && bus_addr == 8'h14);
        end else begin
            rpop = bus_sel && !bus_wr && in_win(bus_addr) && rxq.size() > 0;
            if (rpop) void'(rxq.pop_front());
            full = 0;
            if (rx_valid) begin
                if (rxq.size() < cap) rxq.push_back(rx_char);
                else begin
                    full = 1;
                    if (!fifo_en) rxq[0] = rx_char;
                end
            end
            m_ovr = full || (m_ovr && !(bus_sel && !bus_wr && bus_addr == 8'h14));
            tpop = tx_pop && txq.size() > 0;
            if (tpop) void'(txq.pop_front());
            if (bus_sel && bus_wr && in_win(bus_addr)) begin
                if (txq.size() < cap) txq.push_back(bus_wdata[7:0]);
                else if (!fifo_en) txq[0] = bus_wdata[7:0];
            end
        end
        m_en = fifo_en;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        rx_valid = 0; rx_char = 0; tx_pop = 0;
    endtask

    task automatic do_rd(input logic [7:0] a);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        tick();
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
    endtask

    task automatic do_rx(input logic [7:0] c);
        rx_valid = 1; rx_char = c;
        tick();
    endtask

    task automatic do_pop();
        tx_pop = 1;
        tick();
    endtask

    initial begin
        #100000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        req = "R12"; tick();
        // single-character mode
        req = "R1"; do_rx(8'hA5); do_rd(8'h30);
        req = "R3"; do_rd(8'h44); tick();
        req = "R4"; do_rx(8'h11); do_rx(8'h22); do_rx(8'h33); tick();
        req = "R10"; do_rd(8'h14); do_rd(8'h14);
        req = "R1"; do_rd(8'h6C);
        req = "R7"; do_wr(8'h34, 32'hFFFF_FF5A); do_wr(8'h38, 32'h0000_00C3); tick();
        req = "R9"; do_pop(); tick();
        req = "R2"; do_rx(8'h77); do_rd(8'h2C); do_rd(8'h70); do_wr(8'h70, 32'h99);
        do_wr(8'h14, 32'hFF); do_rd(8'h00); do_rd(8'h64);
        // mode switch with data pending
        req = "R11"; do_rx(8'h66); do_wr(8'h30, 32'h12);
        fifo_en = 1; tick(); tick();
        // queue mode receive
        req = "R5";
        for (int i = 0; i < DEPTH; i++) do_rx(8'(8'h40 + i));
        req = "R6"; do_rx(8'hEE); do_rx(8'hEF); tick();
        req = "R5";
        for (int i = 0; i < DEPTH; i++) do_rd(8'(8'h30 + 4 * (i % 16)));
        req = "R3"; do_rd(8'h50);
        req = "R10"; do_rd(8'h14); tick();
        // full receive path with simultaneous read and arrival
        req = "R6";
        for (int i = 0; i < DEPTH; i++) do_rx(8'(i * 3));
        bus_sel = 1; bus_wr = 0; bus_addr = 8'h3C; rx_valid = 1; rx_char = 8'hBB; tick();
        tick();
        req = "R10";
        bus_sel = 1; bus_wr = 0; bus_addr = 8'h14; rx_valid = 1; rx_char = 8'hCC; tick();
        tick();
        do_rd(8'h14); tick();
        req = "R5";
        for (int i = 0; i < DEPTH + 1; i++) do_rd(8'h30);
        // queue mode transmit
        req = "R8";
        for (int i = 0; i < DEPTH + 2; i++) do_wr(8'(8'h30 + 4 * (i % 16)), 32'(8'h80 + i));
        req = "R9";
        for (int i = 0; i < DEPTH; i++) do_pop();
        tick();
        req = "R9";
        do_wr(8'h40, 32'h5);
        tx_pop = 1; bus_sel = 1; bus_wr = 1; bus_addr = 8'h44; bus_wdata = 32'h6; tick();
        do_pop(); tick();
        // back to single mode
        req = "R11"; do_rx(8'h10); fifo_en = 0; tick(); tick();
        req = "R4"; do_rx(8'h01); do_rx(8'h02); do_rd(8'h58);
        req = "R10"; do_rd(8'h14); tick();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule